// File: doc/BRIEF.md
# Double-Precision Align-and-Add Datapath

This block is the front half of a binary64 adder. It takes two unpacked operands, each made of a sign, an 11-bit biased exponent and a 64-bit extended significand. It returns an unnormalised unpacked result and an invalid-operation flag. A downstream normaliser and rounder finish the job.

For finite operands, the block orders the pair so that the operand with the larger exponent leads. It shifts the other significand right by the exponent gap. Every bit that falls off the right end is folded into the least significant bit. The block then adds the significands when the signs agree and subtracts them when the signs differ. If the larger operand has the all-ones exponent, the block takes a separate path for infinities and NaNs. That path applies a NaN choice rule, or a canonical-NaN mode when it is enabled.

The result is captured in one register stage. A one-bit valid travels with the data.

Top module: `dpadd_core`

## Requirements
- R1: One register stage. When `in_valid` is high at a rising edge, the result appears at that edge and `out_valid` is high for the following cycle. When `in_valid` is low, `out_valid` goes low and all result outputs hold their previous values. Reset (synchronous, `rst_n` low) clears `out_valid`.
- R2: The operands are exchanged only when the exponent of A is strictly below the exponent of B. With equal exponents A stays first. A finite result carries the exponent of the leading operand.
- R3: The trailing significand is shifted right by the exponent difference. The OR of all bits shifted out is ORed into bit 0 of the shifted value. A gap of 64 or more leaves only that sticky bit.
- R4: When the signs are equal, the significands are added without loss: bit 63 is the carry. The result takes the sign of the leading operand.
- R5: When the signs differ, the aligned trailing significand is subtracted from the leading one. A negative difference is negated and the result sign becomes the inverse of the leading operand's sign.
- R6: An exact zero difference is positive. The exception is `round_mode` 2'b10 (toward minus infinity), where it is negative. The other encodings are 2'b00 nearest, 2'b01 toward plus infinity and 2'b11 toward zero.
- R7: Operand encoding: exponent 2047 with significand 0 is an infinity. Exponent 2047 with a nonzero significand is a NaN, quiet when bit 61 is set and signalling otherwise. Finite values hold the hidden bit at bit 62.
- R8: Infinity plus a finite value, or plus an infinity of the same sign, returns that infinity with the flag clear.
- R9: Infinity plus an infinity of the opposite sign returns the canonical quiet NaN with `res_invalid` set. The canonical quiet NaN is sign 0, exponent 2047, significand with only bit 61 set.
- R10: With `dflt_nan_en` low and a NaN among the inputs, the leading operand is returned if it is signalling, or if it is quiet and the trailing operand is not signalling. Otherwise the trailing operand is returned. Either way, bit 61 is set in the returned value.
- R11: With `dflt_nan_en` high, any NaN result is the canonical quiet NaN.
- R12: `res_invalid` is set whenever either input is a signalling NaN. It is clear for all finite inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | 11 | Biased exponent of operand A |
| a_sig | input | 64 | Extended significand of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | 11 | Biased exponent of operand B |
| b_sig | input | 64 | Extended significand of operand B |
| round_mode | input | 2 | Rounding mode, used only for the sign of an exact zero |
| dflt_nan_en | input | 1 | Return the canonical quiet NaN for every NaN result |
| out_valid | output | 1 | Result valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | 11 | Result exponent, unnormalised |
| res_sig | output | 64 | Result significand, unnormalised, with sticky bit 0 |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions check these rules on every cycle:
- the valid pipeline and the holding of the outputs;
- the leading exponent on finite inputs;
- the sign of an exact zero under each rounding mode;
- the canonical NaN in default mode;
- the invalid flag for signalling inputs;
- the survival of a nonzero value through the sticky shifter.

Only the directed scenarios can show:
- the exact significand values produced by alignment, carry-out and negation;
- the order-dependent NaN choice and quieting, including the equal-exponent no-exchange case;
- the handling of infinities.

// File: rtl/dpadd_pkg.sv
// Package: shared constants and the rounding-mode encoding for the
// binary64 align-and-add datapath. Assumes unpacked operands whose
// significand keeps a carry bit on top and guard bits at the bottom.
package dpadd_pkg;
    localparam int EXP_W = 11;
    localparam int SIG_W = 64;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_PLUS    = 2'b01,
        RM_MINUS   = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;
endpackage

// File: rtl/dpadd_order.sv
// Module: puts the operand with the larger exponent first.
// Assumes: equal exponents keep the given order, so the first operand
// keeps its priority in NaN selection. Purely combinational.
module dpadd_order #(
    parameter int EXP_W = dpadd_pkg::EXP_W,
    parameter int SIG_W = dpadd_pkg::SIG_W
) (
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    output logic             n_sign,
    output logic [EXP_W-1:0] n_exp,
    output logic [SIG_W-1:0] n_sig,
    output logic             m_sign,
    output logic [EXP_W-1:0] m_exp,
    output logic [SIG_W-1:0] m_sig,
    output logic [EXP_W-1:0] gap
);
    logic swap;

    // Purpose: exchange only on a strictly smaller first exponent.
    always_comb begin
        swap = (a_exp < b_exp);
        if (swap) begin
            n_sign = b_sign; n_exp = b_exp; n_sig = b_sig;
            m_sign = a_sign; m_exp = a_exp; m_sig = a_sig;
        end else begin
            n_sign = a_sign; n_exp = a_exp; n_sig = a_sig;
            m_sign = b_sign; m_exp = b_exp; m_sig = b_sig;
        end
        gap = n_exp - m_exp;
    end

    // R2: after ordering, the leading exponent is never the smaller one.
    always_comb begin
        if (!$isunknown({a_exp, b_exp}))
            a_r2_lead_not_smaller: assert (n_exp >= m_exp);
    end
endmodule

// File: rtl/dpadd_jam_shift.sv
// Module: logarithmic right shifter that keeps a sticky record of the
// bits it drops.
// Assumes: EXP_W > clog2(SIG_W). At each stage the bits that leave are
// ORed into bit 0. Any shift of SIG_W or more collapses to one sticky bit.
module dpadd_jam_shift #(
    parameter int EXP_W = dpadd_pkg::EXP_W,
    parameter int SIG_W = dpadd_pkg::SIG_W
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [EXP_W-1:0] amount,
    output logic [SIG_W-1:0] sig_out
);
    localparam int SH_W = $clog2(SIG_W);

    logic [SIG_W-1:0] stage [SH_W+1];
    logic             too_far;

    assign stage[0] = sig_in;

    // Purpose: one conditional power-of-two shift per stage, with sticky fold.
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int AMT = 1 << k;
        logic dropped;
        assign dropped = |stage[k][AMT-1:0];
        assign stage[k+1] = amount[k]
            ? ((stage[k] >> AMT) | {{(SIG_W-1){1'b0}}, dropped})
            : stage[k];
    end

    // Purpose: saturate shifts of SIG_W or more to the sticky bit alone.
    always_comb begin
        too_far = |amount[EXP_W-1:SH_W];
        sig_out = too_far ? {{(SIG_W-1){1'b0}}, |sig_in} : stage[SH_W];
    end

    // R3: a nonzero value never vanishes through the shifter.
    always_comb begin
        if (!$isunknown({sig_in, amount}))
            a_r3_sticky_kept: assert ((sig_in == '0) || (sig_out != '0));
    end
endmodule

// File: rtl/dpadd_special.sv
// Module: result for the case where the leading operand has the all-ones
// exponent (an infinity or a NaN).
// Assumes: the caller uses these outputs only in that case. The trailing
// operand may be anything.
module dpadd_special #(
    parameter int EXP_W = dpadd_pkg::EXP_W,
    parameter int SIG_W = dpadd_pkg::SIG_W
) (
    input  logic             n_sign,
    input  logic [SIG_W-1:0] n_sig,
    input  logic             m_sign,
    input  logic [EXP_W-1:0] m_exp,
    input  logic [SIG_W-1:0] m_sig,
    input  logic             dflt_nan_en,
    output logic             sp_sign,
    output logic [EXP_W-1:0] sp_exp,
    output logic [SIG_W-1:0] sp_sig,
    output logic             sp_invalid
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam int               QBIT    = SIG_W - 3;
    localparam logic [SIG_W-1:0] QMASK   = {{(SIG_W-1){1'b0}}, 1'b1} << QBIT;

    logic n_nan, m_nan, n_snan, m_snan, n_qnan, m_inf, take_n;

    // Purpose: classify both operands.
    always_comb begin
        n_nan  = (n_sig != '0);
        m_nan  = (m_exp == EXP_MAX) && (m_sig != '0);
        m_inf  = (m_exp == EXP_MAX) && (m_sig == '0);
        n_snan = n_nan && !n_sig[QBIT];
        n_qnan = n_nan &&  n_sig[QBIT];
        m_snan = m_nan && !m_sig[QBIT];
        take_n = n_snan || (!m_snan && n_qnan);
    end

    // Purpose: choose a NaN, the canonical NaN, or the infinity.
    always_comb begin
        sp_exp     = EXP_MAX;
        sp_sign    = n_sign;
        sp_sig     = '0;
        sp_invalid = 1'b0;
        if (n_nan || m_nan) begin
            sp_invalid = n_snan || m_snan;
            if (dflt_nan_en) begin
                sp_sign = 1'b0;
                sp_sig  = QMASK;
            end else if (take_n) begin
                sp_sign = n_sign;
                sp_sig  = n_sig | QMASK;
            end else begin
                sp_sign = m_sign;
                sp_sig  = m_sig | QMASK;
            end
        end else if (m_inf && (m_sign != n_sign)) begin
            sp_sign    = 1'b0;
            sp_sig     = QMASK;
            sp_invalid = 1'b1;
        end
    end
endmodule

// File: rtl/dpadd_core.sv
// Module: top of the binary64 align-and-add datapath. It orders, aligns
// and adds or subtracts two unpacked operands, handles special values,
// and registers the unnormalised result once.
// Assumes: synchronous active-low reset. Finite significands keep bit
// SIG_W-1 clear so that the carry fits. Rounding is done downstream.
module dpadd_core #(
    parameter int EXP_W = dpadd_pkg::EXP_W,
    parameter int SIG_W = dpadd_pkg::SIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    input  logic [1:0]       round_mode,
    input  logic             dflt_nan_en,
    output logic             out_valid,
    output logic             res_sign,
    output logic [EXP_W-1:0] res_exp,
    output logic [SIG_W-1:0] res_sig,
    output logic             res_invalid
);
    import dpadd_pkg::*;

    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam int               QBIT    = SIG_W - 3;
    localparam logic [SIG_W-1:0] QMASK   = {{(SIG_W-1){1'b0}}, 1'b1} << QBIT;

    logic             n_sign, m_sign;
    logic [EXP_W-1:0] n_exp, m_exp, gap;
    logic [SIG_W-1:0] n_sig, m_sig, m_aligned;
    logic             sp_sign, sp_invalid;
    logic [EXP_W-1:0] sp_exp;
    logic [SIG_W-1:0] sp_sig;
    logic             fin_sign;
    logic [SIG_W-1:0] fin_sig, diff;
    logic             nx_sign, nx_invalid;
    logic [EXP_W-1:0] nx_exp;
    logic [SIG_W-1:0] nx_sig;

    dpadd_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_order (
        .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
        .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
        .n_sign(n_sign), .n_exp(n_exp), .n_sig(n_sig),
        .m_sign(m_sign), .m_exp(m_exp), .m_sig(m_sig),
        .gap(gap)
    );

    dpadd_jam_shift #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_shift (
        .sig_in(m_sig), .amount(gap), .sig_out(m_aligned)
    );

    dpadd_special #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_special (
        .n_sign(n_sign), .n_sig(n_sig),
        .m_sign(m_sign), .m_exp(m_exp), .m_sig(m_sig),
        .dflt_nan_en(dflt_nan_en),
        .sp_sign(sp_sign), .sp_exp(sp_exp), .sp_sig(sp_sig),
        .sp_invalid(sp_invalid)
    );

    // Purpose: finite add or subtract, with negation and zero-sign fixing.
    always_comb begin
        diff     = n_sig - m_aligned;
        fin_sign = n_sign;
        fin_sig  = n_sig + m_aligned;
        if (n_sign != m_sign) begin
            if (diff[SIG_W-1]) begin
                fin_sig  = -diff;
                fin_sign = ~n_sign;
            end else if (diff == '0) begin
                fin_sig  = '0;
                fin_sign = (rmode_e'(round_mode) == RM_MINUS);
            end else begin
                fin_sig  = diff;
            end
        end
    end

    // Purpose: choose between the special-value path and the finite path.
    always_comb begin
        if (n_exp == EXP_MAX) begin
            nx_sign = sp_sign; nx_exp = sp_exp; nx_sig = sp_sig;
            nx_invalid = sp_invalid;
        end else begin
            nx_sign = fin_sign; nx_exp = n_exp; nx_sig = fin_sig;
            nx_invalid = 1'b0;
        end
    end

    // Purpose: the single result register and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            res_sign    <= 1'b0;
            res_exp     <= '0;
            res_sig     <= '0;
            res_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_sign    <= nx_sign;
                res_exp     <= nx_exp;
                res_sig     <= nx_sig;
                res_invalid <= nx_invalid;
            end
        end
    end

    // R1: valid follows one cycle later; idle cycles hold the result.
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_sig) && $stable(res_exp)));

    // R2: a finite pair yields the larger exponent.
    a_r2_lead_exponent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_exp != EXP_MAX && b_exp != EXP_MAX)
        |=> res_exp == $past((a_exp > b_exp) ? a_exp : b_exp));

    // R6: an exact cancellation is negative only when rounding toward minus infinity.
    a_r6_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_exp != EXP_MAX && a_sign != b_sign && a_exp == b_exp && a_sig == b_sig)
        |=> (res_sig == '0 && res_sign == $past(round_mode == 2'b10)));

    // R11: default mode always gives the canonical quiet NaN.
    a_r11_canonical_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dflt_nan_en &&
         ((a_exp == EXP_MAX && a_sig != '0) || (b_exp == EXP_MAX && b_sig != '0)))
        |=> (!res_sign && res_exp == EXP_MAX && res_sig == QMASK));

    // R12: a signalling input always raises the invalid flag.
    a_r12_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((a_exp == EXP_MAX && a_sig != '0 && !a_sig[QBIT]) ||
                      (b_exp == EXP_MAX && b_sig != '0 && !b_sig[QBIT])))
        |=> res_invalid);
endmodule

// File: tb/test_dpadd_core.sv
module test_dpadd_core;
    localparam logic [10:0] MX   = 11'h7FF;
    localparam logic [63:0] ONE  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] QB   = 64'h2000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        a_sign = 1'b0, b_sign = 1'b0;
    logic [10:0] a_exp = '0, b_exp = '0;
    logic [63:0] a_sig = '0, b_sig = '0;
    logic [1:0]  round_mode = 2'b00;
    logic        dflt_nan_en = 1'b0;
    logic        out_valid, res_sign, res_invalid;
    logic [10:0] res_exp;
    logic [63:0] res_sig;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dpadd_core i_dpadd_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
        .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
        .round_mode(round_mode), .dflt_nan_en(dflt_nan_en),
        .out_valid(out_valid), .res_sign(res_sign), .res_exp(res_exp),
        .res_sig(res_sig), .res_invalid(res_invalid)
    );

    task automatic check(string req, logic s, logic [10:0] e, logic [63:0] g, logic inv);
        n_vec++;
        if (!out_valid || res_sign !== s || res_exp !== e || res_sig !== g || res_invalid !== inv) begin
            n_bad++;
            $display("FAIL %s: got v=%0b s=%0b e=%h g=%h inv=%0b, expected v=1 s=%0b e=%h g=%h inv=%0b",
                     req, out_valid, res_sign, res_exp, res_sig, res_invalid, s, e, g, inv);
        end
    endtask

    task automatic apply(logic as, logic [10:0] ae, logic [63:0] ag,
                         logic bs, logic [10:0] be, logic [63:0] bg);
        @(negedge clk);
        a_sign = as; a_exp = ae; a_sig = ag;
        b_sign = bs; b_exp = be; b_sig = bg;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got out_valid=%0b expected 0", out_valid);
        end
    endtask

    task automatic t_same_sign();
        apply(0, 11'd1023, ONE, 0, 11'd1023, ONE);
        check("R4 carry add", 0, 11'd1023, 64'h8000_0000_0000_0000, 0);
        apply(1, 11'd1023, ONE, 1, 11'd1022, ONE);
        check("R4 negative add", 1, 11'd1023, 64'h6000_0000_0000_0000, 0);
    endtask

    task automatic t_align();
        apply(0, 11'd1030, ONE, 0, 11'd1023, ONE | 64'd1);
        check("R3 sticky shift by 7", 0, 11'd1030, 64'h4080_0000_0000_0001, 0);
        apply(0, 11'd1200, ONE, 0, 11'd1100, ONE);
        check("R3 shift past width", 0, 11'd1200, ONE | 64'd1, 0);
    endtask

    task automatic t_swap_sub();
        apply(0, 11'd1023, ONE, 1, 11'd1025, ONE);
        check("R2 R5 swapped subtract", 1, 11'd1025, 64'h3000_0000_0000_0000, 0);
        apply(0, 11'd1023, ONE, 1, 11'd1023, 64'h6000_0000_0000_0000);
        check("R5 negated difference", 1, 11'd1023, 64'h2000_0000_0000_0000, 0);
    endtask

    task automatic t_zero();
        round_mode = 2'b00;
        apply(0, 11'd1000, ONE, 1, 11'd1000, ONE);
        check("R6 zero nearest", 0, 11'd1000, 64'd0, 0);
        round_mode = 2'b10;
        apply(0, 11'd1000, ONE, 1, 11'd1000, ONE);
        check("R6 zero minus", 1, 11'd1000, 64'd0, 0);
        round_mode = 2'b11;
        apply(1, 11'd1000, ONE, 0, 11'd1000, ONE);
        check("R6 zero toward zero", 0, 11'd1000, 64'd0, 0);
        round_mode = 2'b00;
    endtask

    task automatic t_inf();
        apply(0, MX, 64'd0, 1, 11'd1023, ONE);
        check("R7 R8 inf plus finite", 0, MX, 64'd0, 0);
        apply(1, 11'd5, ONE, 1, MX, 64'd0);
        check("R8 finite plus neg inf", 1, MX, 64'd0, 0);
        apply(0, MX, 64'd0, 0, MX, 64'd0);
        check("R8 same-sign infs", 0, MX, 64'd0, 0);
        apply(1, MX, 64'd0, 0, MX, 64'd0);
        check("R9 opposite infs", 0, MX, QB, 1);
    endtask

    task automatic t_nan_pick();
        dflt_nan_en = 1'b0;
        apply(1, MX, QB | 64'h1_0000, 0, MX, 64'h2_0000);
        check("R10 R12 quiet then signalling", 0, MX, QB | 64'h2_0000, 1);
        apply(1, MX, 64'h3_0000, 0, MX, QB | 64'h4_0000);
        check("R10 R12 signalling first", 1, MX, QB | 64'h3_0000, 1);
        apply(0, MX, QB | 64'h5_0000, 1, MX, QB | 64'h6_0000);
        check("R10 two quiet", 0, MX, QB | 64'h5_0000, 0);
        apply(0, 11'd5, ONE, 1, MX, QB | 64'h7_0000);
        check("R10 finite then quiet", 1, MX, QB | 64'h7_0000, 0);
        apply(0, MX, 64'd0, 1, MX, QB | 64'h8_0000);
        check("R10 inf then quiet", 1, MX, QB | 64'h8_0000, 0);
    endtask

    task automatic t_default_nan();
        dflt_nan_en = 1'b1;
        apply(1, MX, 64'h9_0000, 0, 11'd3, ONE);
        check("R11 R12 default signalling", 0, MX, QB, 1);
        apply(0, 11'd3, ONE, 1, MX, QB | 64'hA_0000);
        check("R11 default quiet", 0, MX, QB, 0);
        dflt_nan_en = 1'b0;
    endtask

    task automatic t_hold();
        apply(0, 11'd1023, ONE, 0, 11'd1023, ONE);
        @(negedge clk);
        a_exp = 11'd7; b_exp = 11'd9; a_sig = 64'd1; b_sig = 64'd2;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || res_sig !== 64'h8000_0000_0000_0000 || res_exp !== 11'd1023) begin
            n_bad++;
            $display("FAIL R1 hold: got v=%0b e=%h g=%h expected v=0 e=3ff g=8000000000000000",
                     out_valid, res_exp, res_sig);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_same_sign();
        t_align();
        t_swap_sub();
        t_zero();
        t_inf();
        t_nan_pick();
        t_default_nan();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule